// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns an effective address into a physical address once a block-translation lookup has already failed. It searches a hashed page table held in big-endian memory. One of sixteen segment registers supplies a 24-bit virtual segment ID. That ID is combined with the page index to pick a 64-byte group of eight two-word entries. The walker scans the group in ascending order through a plain request/valid read port. When that first pass finds nothing, it repeats the scan on a second group chosen by the inverted hash.

A hit completes the walk with the translated address, using 128 KiB pages. A miss in both passes completes the walk with a precise storage-exception event instead. That event carries the new values for the two save/restore registers, the fault address, the fault status, the machine state and the program counter. The surrounding core starts a walk with a one-cycle request while the walker is idle. A one-cycle completion pulse, qualified by a fault flag, marks the end of the walk.

Top module: `hpt_walker`

## Requirements
- R1: After synchronous reset, `done`, `fault`, `busy` and `mem_req` are all 0.
- R2: `req_ea[31:28]` picks segment register n, which is `seg_regs[32n+31:32n]`. The segment ID is that register's bits 23:0. Bits 31:24 of the register have no effect.
- R3: The page index is EA[27:17]. The first hash is (ID XOR index) AND 0x7FFFF. The group base is (base AND 0xFFFF0000) OR (((hash>>10) AND (base AND 0x1FF))<<16), plus (hash AND 0x3FF)*64. Slot k's first word sits at base+8k, and its second word at base+8k+4. The first read of a walk goes to slot 0 of the first group.
- R4: First-word fields are: bit 31 valid, bits 30:7 segment ID, bit 6 hash select, bits 5:0 short index. An entry matches only when it is valid, its ID equals the segment ID, its short index equals (page index >> 5), and its hash select equals the pass number (0 or 1).
- R5: After eight non-matching entries in pass 0, pass 1 scans a group built from the 19-bit NOT of the first hash. A second word is read only for a matching entry, so a hit in slot k of pass p takes 8p+k+2 reads.
- R6: On a hit, `pa` = (EA AND 0x1FFFF) OR (second word[31:12] << 12).
- R7: When both passes miss, `fault`=1 and the outputs are: save_pc = request PC, save_msr = MSR AND 0x87C0FFFF, fault_addr = EA, fault_status = 0x40000000, new MSR = MSR AND NOT 0x0004EF36, new PC = 0xFFF00300.
- R8: `req_valid` is ignored while `busy` is 1. Such a request changes neither the running walk nor the number of completions.
- R9: `mem_req` and `mem_addr` stay steady from the moment a read is raised until `mem_valid` answers it, for any memory latency.
- R10: `done` is a single-cycle pulse and `busy` is 0 in that cycle. `fault` is 1 only together with `done`.
- R11: When several entries in one group match, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_ea | input | 32 | Effective address to translate |
| req_pc | input | 32 | Program counter of the access |
| req_msr | input | 32 | Machine state at the access |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register n at bits 32n+31:32n |
| table_base | input | 32 | Page-table base and mask register |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read word, lowest-addressed byte in bits 31:24 |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Completion is a storage exception |
| pa | output | 32 | Translated address |
| exc_save_pc | output | 32 | New save/restore register 0 |
| exc_save_msr | output | 32 | New save/restore register 1 |
| exc_fault_addr | output | 32 | New fault address register |
| exc_fault_status | output | 32 | New fault status register |
| exc_msr | output | 32 | New machine state register |
| exc_pc | output | 32 | New program counter |

## Verification
The bench sweeps the hit slot across all eight positions in both passes. Each sweep puts decoy entries in the earlier slots, and each decoy is wrong in exactly one field: the valid bit, the segment ID, the short index or the hash select. A comparator that skipped any field would stop on a decoy, giving the wrong address and the wrong read count. Sweeping every slot in pass 1 catches a secondary group built from a bad hash inversion, because the 9th read then lands at the wrong address.

A completely empty table checks each exception output against masks computed in the bench. A mis-masked MSR or a wrong vector shows up as a value mismatch. Two valid matches in one group check that the lowest slot wins. A request raised in the middle of a walk must neither change the fault address nor produce a second completion. The memory latency varies between cases, so a walker that let go of its request early would read the wrong word.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

    localparam int ADDR_W     = 32;
    localparam int VSID_W     = 24;
    localparam int PIDX_W     = 11;
    localparam int HASH_W     = 19;
    localparam int OFF_W      = 17;
    localparam int API_W      = 6;
    localparam int SEG_SEL_W  = 4;
    localparam int SEG_COUNT  = 1 << SEG_SEL_W;
    localparam int GRP_LO_W   = 10;
    localparam int MASK_W     = 9;
    localparam int RPN_W      = 20;

    localparam logic [31:0] SRR1_KEEP   = 32'h87C0_FFFF;
    localparam logic [31:0] MSR_CLEAR   = 32'h0004_EF36;
    localparam logic [31:0] STORAGE_VEC = 32'hFFF0_0300;
    localparam logic [31:0] FSR_NOMATCH = 32'h4000_0000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_PHYS = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic              valid;
        logic [VSID_W-1:0] vsid;
        logic              hsel;
        logic [API_W-1:0]  api;
    } pte_tag_t;

    typedef struct packed {
        logic [31:0] save_pc;
        logic [31:0] save_msr;
        logic [31:0] fault_addr;
        logic [31:0] fault_status;
        logic [31:0] new_msr;
        logic [31:0] new_pc;
    } storage_exc_t;

    function automatic pte_tag_t unpack_tag(input logic [31:0] w);
        pte_tag_t t;
        t.valid = w[31];
        t.vsid  = w[30:7];
        t.hsel  = w[6];
        t.api   = w[5:0];
        return t;
    endfunction

    function automatic logic [HASH_W-1:0] base_hash(input logic [VSID_W-1:0] vsid,
                                                    input logic [PIDX_W-1:0] pidx);
        return vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
    endfunction

endpackage

// File: rtl/hptw_group_addr.sv
module hptw_group_addr
    import hptw_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int GRP_SH = $clog2(SLOTS * 8)
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              pass,
    input  logic [31:0]       base,
    input  logic [SLOT_W-1:0] slot,
    input  logic              word_sel,
    output logic [31:0]       addr
);
    logic [HASH_W-1:0]       hash_first;
    logic [HASH_W-1:0]       hash_cur;
    logic [MASK_W-1:0]       hi_bits;
    logic [31:0]             grp_base;
    logic [31:0]             grp_off;
    logic [31:0]             slot_off;

    always_comb begin
        hash_first = base_hash(vsid, pidx);
        hash_cur   = pass ? ~hash_first : hash_first;
        hi_bits    = hash_cur[HASH_W-1:GRP_LO_W] & base[MASK_W-1:0];
        grp_base   = {base[31:16], 16'h0000} | {7'b0, hi_bits, 16'h0000};
        grp_off    = 32'(hash_cur[GRP_LO_W-1:0]) << GRP_SH;
        slot_off   = (32'(slot) << 3) | (32'(word_sel) << 2);
        addr       = grp_base + grp_off + slot_off;
    end
endmodule

// File: rtl/hptw_entry_cmp.sv
module hptw_entry_cmp
    import hptw_pkg::*;
(
    input  logic [31:0]       word0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              pass,
    output logic              hit
);
    pte_tag_t tag;

    always_comb begin
        tag = unpack_tag(word0);
        hit = tag.valid && (tag.vsid == vsid) && (tag.api == api) && (tag.hsel == pass);
    end
endmodule

// File: rtl/hptw_exc_gen.sv
module hptw_exc_gen
    import hptw_pkg::*;
(
    input  logic [31:0]  pc,
    input  logic [31:0]  msr,
    input  logic [31:0]  ea,
    output storage_exc_t exc
);
    always_comb begin
        exc.save_pc      = pc;
        exc.save_msr     = msr & SRR1_KEEP;
        exc.fault_addr   = ea;
        exc.fault_status = FSR_NOMATCH;
        exc.new_msr      = msr & ~MSR_CLEAR;
        exc.new_pc       = STORAGE_VEC;
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hptw_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [31:0]             req_ea,
    input  logic [31:0]             req_pc,
    input  logic [31:0]             req_msr,
    input  logic [SEG_COUNT*32-1:0] seg_regs,
    input  logic [31:0]             table_base,
    output logic                    busy,
    output logic                    mem_req,
    output logic [31:0]             mem_addr,
    input  logic                    mem_valid,
    input  logic [31:0]             mem_rdata,
    output logic                    done,
    output logic                    fault,
    output logic [31:0]             pa,
    output logic [31:0]             exc_save_pc,
    output logic [31:0]             exc_save_msr,
    output logic [31:0]             exc_fault_addr,
    output logic [31:0]             exc_fault_status,
    output logic [31:0]             exc_msr,
    output logic [31:0]             exc_pc
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [VSID_W-1:0] seg_vsid [SEG_COUNT];

    for (genvar gi = 0; gi < SEG_COUNT; gi++) begin : g_seg
        assign seg_vsid[gi] = seg_regs[gi*32 +: VSID_W];
    end

    walk_state_e       state_q;
    logic              pass_q;
    logic [SLOT_W-1:0] slot_q;
    logic [31:0]       ea_q;
    logic [31:0]       pc_q;
    logic [31:0]       msr_q;
    logic [31:0]       base_q;
    logic [VSID_W-1:0] vsid_q;
    logic              done_q;
    logic              fault_q;
    logic [31:0]       pa_q;
    storage_exc_t      exc_q;

    logic [PIDX_W-1:0] pidx;
    logic [API_W-1:0]  api;
    logic              entry_hit;
    storage_exc_t      exc_c;

    assign pidx = ea_q[OFF_W +: PIDX_W];
    assign api  = pidx[PIDX_W-1 -: API_W];

    hptw_group_addr #(.SLOTS(SLOTS)) u_addr (
        .vsid     (vsid_q),
        .pidx     (pidx),
        .pass     (pass_q),
        .base     (base_q),
        .slot     (slot_q),
        .word_sel (state_q == ST_PHYS),
        .addr     (mem_addr)
    );

    hptw_entry_cmp u_cmp (
        .word0 (mem_rdata),
        .vsid  (vsid_q),
        .api   (api),
        .pass  (pass_q),
        .hit   (entry_hit)
    );

    hptw_exc_gen u_exc (
        .pc  (pc_q),
        .msr (msr_q),
        .ea  (ea_q),
        .exc (exc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= 1'b0;
            slot_q  <= '0;
            ea_q    <= '0;
            pc_q    <= '0;
            msr_q   <= '0;
            base_q  <= '0;
            vsid_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
            exc_q   <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ea_q    <= req_ea;
                        pc_q    <= req_pc;
                        msr_q   <= req_msr;
                        base_q  <= table_base;
                        vsid_q  <= seg_vsid[req_ea[31:32-SEG_SEL_W]];
                        pass_q  <= 1'b0;
                        slot_q  <= '0;
                        state_q <= ST_TAG;
                    end
                end
                ST_TAG: begin
                    if (mem_valid) begin
                        if (entry_hit) begin
                            state_q <= ST_PHYS;
                        end else if (slot_q != LAST_SLOT) begin
                            slot_q <= slot_q + 1'b1;
                        end else if (!pass_q) begin
                            pass_q <= 1'b1;
                            slot_q <= '0;
                        end else begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            exc_q   <= exc_c;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_PHYS: begin
                    if (mem_valid) begin
                        pa_q    <= (ea_q & 32'h0001_FFFF) | {mem_rdata[31:32-RPN_W], 12'h000};
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy             = (state_q != ST_IDLE);
    assign mem_req          = busy;
    assign done             = done_q;
    assign fault            = fault_q;
    assign pa               = pa_q;
    assign exc_save_pc      = exc_q.save_pc;
    assign exc_save_msr     = exc_q.save_msr;
    assign exc_fault_addr   = exc_q.fault_addr;
    assign exc_fault_status = exc_q.fault_status;
    assign exc_msr          = exc_q.new_msr;
    assign exc_pc           = exc_q.new_pc;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        done,
    input logic        fault,
    input logic [31:0] pa,
    input logic [31:0] ea_q,
    input logic [31:0] exc_msr
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_fault_qual_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    p_hit_offset_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (pa[11:0] == ea_q[11:0]));

    p_fault_msr_r7: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> ((exc_msr & 32'h0004_EF36) == 32'h0));
endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .done      (done),
    .fault     (fault),
    .pa        (pa),
    .ea_q      (ea_q),
    .exc_msr   (exc_msr)
);

// File: tb/sim_hpt_walker.sv
`timescale 1ns/1ps
module sim_hpt_walker;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [31:0]  req_ea = '0;
    logic [31:0]  req_pc = '0;
    logic [31:0]  req_msr = '0;
    logic [511:0] seg_regs = '0;
    logic [31:0]  table_base = 32'h00A0_0003;
    logic         busy, mem_req, done, fault;
    logic [31:0]  mem_addr, pa;
    logic         mem_valid = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic [31:0]  e_spc, e_smsr, e_far, e_fsr, e_msr, e_pc;

    always #2.5 clk = ~clk;

    hpt_walker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
        .req_pc(req_pc), .req_msr(req_msr), .seg_regs(seg_regs),
        .table_base(table_base), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .pa(pa),
        .exc_save_pc(e_spc), .exc_save_msr(e_smsr), .exc_fault_addr(e_far),
        .exc_fault_status(e_fsr), .exc_msr(e_msr), .exc_pc(e_pc)
    );

    int total = 0;
    int bad = 0;

    logic [31:0] mem [logic [31:0]];
    int          lat = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_log [64];
    int          done_cnt = 0;

    // memory model: captures a held request, answers after lat cycles
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [31:0] a = '0;
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
            end else if (!pend && mem_req) begin
                pend = 1;
                cnt = lat;
                a = mem_addr;
                if (rd_cnt < 64) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rdata = mem.exists(a) ? mem[a] : 32'h0;
                    mem_valid = 1'b1;
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
        end
    end

    always @(posedge clk) if (!rst && done) done_cnt <= done_cnt + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seg_val(input int i);
        return 32'hE100_0000 | ((32'(i) * 32'h0001_3579 + 32'h0000_00A5) & 32'h00FF_FFFF);
    endfunction

    function automatic logic [18:0] hash_of(input logic [23:0] vsid, input logic [10:0] pidx, input int pass);
        logic [31:0] h;
        h = (32'(vsid) ^ 32'(pidx)) & 32'h7FFFF;
        if (pass == 1) h = (~h) & 32'h7FFFF;
        return h[18:0];
    endfunction

    function automatic logic [31:0] group_of(input logic [18:0] h);
        logic [31:0] hh;
        hh = 32'(h);
        return ((table_base & 32'hFFFF_0000) | (((hh >> 10) & (table_base & 32'h1FF)) << 16))
               + (hh & 32'h3FF) * 64;
    endfunction

    // first word layout per R4: {valid, vsid[23:0], hsel, api[5:0]}
    function automatic logic [31:0] mk_w0(input bit v, input logic [23:0] vsid, input bit h, input logic [5:0] api);
        return {v, vsid, h, api};
    endfunction

    // decoy wrong in exactly one field, kind 0..3
    function automatic logic [31:0] decoy(input int kind, input logic [23:0] vsid, input bit h, input logic [5:0] api);
        case (kind % 4)
            0: return mk_w0(1'b0, vsid, h, api);
            1: return mk_w0(1'b1, vsid ^ 24'h000100, h, api);
            2: return mk_w0(1'b1, vsid, h, api ^ 6'h01);
            default: return mk_w0(1'b1, vsid, ~h, api);
        endcase
    endfunction

    bit          r_fault;
    logic [31:0] r_pa;

    task automatic walk(input logic [31:0] ea, input logic [31:0] pc, input logic [31:0] msr,
                        input int lat_i, input bit poke);
        int n;
        int d0;
        @(negedge clk);
        lat = lat_i;
        rd_cnt = 0;
        d0 = done_cnt;
        req_ea = ea; req_pc = pc; req_msr = msr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                req_ea = ea ^ 32'h5000_0000; req_valid = 1'b1;
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        r_fault = fault;
        r_pa = pa;
        chk(done === 1'b1, "R10 done seen", 32'(done), 32'h1);
        chk(busy === 1'b0, "R10 idle with done", 32'(busy), 32'h0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", 32'(done), 32'h0);
        chk(fault === 1'b0, "R10 fault only with done", 32'(fault), 32'h0);
        chk(done_cnt - d0 == 1, "R8 single completion", 32'(done_cnt - d0), 32'h1);
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = seg_val(i);
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && fault === 1'b0, "R1 reset done/fault", {30'b0, done, fault}, 32'h0);
        chk(busy === 1'b0 && mem_req === 1'b0, "R1 reset busy/req", {30'b0, busy, mem_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0, "R1 idle after reset", {30'b0, busy, mem_req}, 32'h0);

        // pass-0 sweep: hit at slot s, single-field decoys before it (R2 R3 R4 R6 R11)
        for (int s = 0; s < 8; s++) begin
            logic [10:0] pidx; logic [23:0] vsid; logic [31:0] ea, g, rpn_w, expd;
            pidx = 11'((s * 173 + 5) % 2048);
            vsid = seg_val(s)[23:0];
            ea = {4'(s), pidx, 17'h1ABCD ^ 17'(s)};
            g = group_of(hash_of(vsid, pidx, 0));
            mem.delete();
            for (int k = 0; k < s; k++) mem[g + 32'(k) * 8] = decoy(k + s, vsid, 1'b0, pidx[10:5]);
            mem[g + 32'(s) * 8] = mk_w0(1'b1, vsid, 1'b0, pidx[10:5]);
            rpn_w = {20'hABC00 + 20'(s * 7), 12'h5A5};
            mem[g + 32'(s) * 8 + 4] = rpn_w;
            walk(ea, 32'h1000, 32'h0, s % 4, 1'b0);
            expd = (ea & 32'h1FFFF) | ({12'h0, rpn_w[31:12]} << 12);
            chk(r_fault == 1'b0, "R4 primary hit no fault", 32'(r_fault), 32'h0);
            chk(r_pa == expd, "R6 primary pa", r_pa, expd);
            chk(rd_log[0] == g, "R3 first read group base", rd_log[0], g);
            chk(rd_cnt == s + 2, "R5 read count pass0", 32'(rd_cnt), 32'(s + 2));
            chk(rd_log[s + 1] == g + 32'(s) * 8 + 4, "R3 second word address", rd_log[s + 1], g + 32'(s) * 8 + 4);
        end

        // pass-1 sweep on segments 8..15 (R5 R4)
        for (int s = 0; s < 8; s++) begin
            logic [10:0] pidx; logic [23:0] vsid; logic [31:0] ea, g0, g1, expd;
            pidx = 11'((s * 311 + 1000) % 2048);
            vsid = seg_val(8 + s)[23:0];
            ea = {4'(8 + s), pidx, 17'(s * 4099)};
            g0 = group_of(hash_of(vsid, pidx, 0));
            g1 = group_of(hash_of(vsid, pidx, 1));
            mem.delete();
            for (int k = 0; k < 8; k++) mem[g0 + 32'(k) * 8] = decoy(k, vsid, 1'b0, pidx[10:5]);
            mem[g0 + 32'(s) * 8] = mk_w0(1'b1, vsid, 1'b1, pidx[10:5]);
            for (int k = 0; k < s; k++) mem[g1 + 32'(k) * 8] = mk_w0(1'b1, vsid, 1'b0, pidx[10:5]);
            mem[g1 + 32'(s) * 8] = mk_w0(1'b1, vsid, 1'b1, pidx[10:5]);
            mem[g1 + 32'(s) * 8 + 4] = 32'h0F0F_3000 + 32'(s) * 32'h1000;
            walk(ea, 32'h2000, 32'h0, (s + 1) % 3, 1'b0);
            expd = (ea & 32'h1FFFF) | (32'h0F0F_3000 + 32'(s) * 32'h1000);
            chk(r_fault == 1'b0, "R5 secondary hit no fault", 32'(r_fault), 32'h0);
            chk(r_pa == expd, "R6 secondary pa", r_pa, expd);
            chk(rd_log[8] == g1, "R5 secondary group base", rd_log[8], g1);
            chk(rd_cnt == 8 + s + 2, "R5 read count pass1", 32'(rd_cnt), 32'(8 + s + 2));
        end

        // priority among two matches (R11)
        begin
            logic [10:0] pidx; logic [23:0] vsid; logic [31:0] ea, g, expd;
            pidx = 11'h2C3; vsid = seg_val(3)[23:0];
            ea = {4'd3, pidx, 17'h00F0F};
            g = group_of(hash_of(vsid, pidx, 0));
            mem.delete();
            mem[g + 16] = mk_w0(1'b1, vsid, 1'b0, pidx[10:5]);
            mem[g + 20] = 32'h1234_5000;
            mem[g + 40] = mk_w0(1'b1, vsid, 1'b0, pidx[10:5]);
            mem[g + 44] = 32'h7777_7000;
            walk(ea, 32'h0, 32'h0, 1, 1'b0);
            expd = (ea & 32'h1FFFF) | 32'h1234_5000;
            chk(r_pa == expd, "R11 lowest slot wins", r_pa, expd);
            chk(rd_cnt == 4, "R11 read count", 32'(rd_cnt), 32'h4);
        end

        // double miss: exception outputs (R7), two MSR patterns, one with a busy poke (R8)
        for (int t = 0; t < 2; t++) begin
            logic [31:0] ea, pc, msr;
            ea  = (t == 0) ? 32'h7654_3210 : 32'hC001_D00D;
            pc  = (t == 0) ? 32'h0100_0ABC : 32'h8000_1234;
            msr = (t == 0) ? 32'hFFFF_FFFF : 32'h0000_2032;
            mem.delete();
            walk(ea, pc, msr, t + 2, t == 1);
            chk(r_fault == 1'b1, "R7 fault flag", 32'(r_fault), 32'h1);
            chk(rd_cnt == 16, "R7 sixteen reads", 32'(rd_cnt), 32'd16);
            chk(e_spc == pc, "R7 save pc", e_spc, pc);
            chk(e_smsr == (msr & 32'h87C0FFFF), "R7 save msr", e_smsr, msr & 32'h87C0FFFF);
            chk(e_far == ea, "R7 R8 fault address", e_far, ea);
            chk(e_fsr == 32'h4000_0000, "R7 fault status", e_fsr, 32'h4000_0000);
            chk(e_msr == (msr & ~32'h0004EF36), "R7 new msr", e_msr, msr & ~32'h0004EF36);
            chk(e_pc == 32'hFFF0_0300, "R7 new pc", e_pc, 32'hFFF0_0300);
        end

        repeat (4) @(negedge clk);
        chk(busy === 1'b0, "R8 no walk from poke", 32'(busy), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule